// File: doc/BRIEF.md
# Two-Edge Period Timestamp Unit

This block measures the period of a slow digital signal against the local clock. A free-running up counter advances by one on every clock. After an arm strobe, the block takes the counter value at the first accepted rising edge of the input as the start stamp. It takes the counter value at the next accepted rising edge as the stop stamp. It then stops capturing and raises a done flag.

The elapsed count, stop minus start modulo 2^CNT_W, is the input period in clock cycles. A single counter wrap between the two edges still gives the correct value. Before any edge is accepted, the input is resynchronised and filtered. The filter samples the input once every DIV_RATE clocks and changes its level only after FILT_LEN equal samples in a row.

Software turns the elapsed count into a frequency. One arm gives exactly one start/stop pair. If an unexpected capture arrives in a state that should not see one, the step machine goes back to idle and capture is switched off.

Top module: `period_capture_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, done_o is 0 and start_stamp_o, stop_stamp_o and elapsed_o are all 0.
- R2: The reference counter is CNT_W bits wide (default 32). It starts at CNT_INIT (default 0) and adds 1 on every clock. After all ones it rolls over to zero.
- R3: The input is sampled once every DIV_RATE clocks (default 4). An edge counts only after FILT_LEN (default 2) samples in a row are high, following a filtered low level. A high pulse shorter than DIV_RATE cycles is never accepted as an edge.
- R4: Rising edges that arrive before the first arm strobe have no effect. done_o stays 0 and start_stamp_o stays 0.
- R5: After an arm strobe, the first accepted rising edge sets the start stamp and the second sets the stop stamp. On the second edge done_o goes to 1 and elapsed_o equals stop_stamp_o minus start_stamp_o. For an input period of P cycles, where P is a multiple of DIV_RATE, elapsed_o equals P.
- R6: Once done_o is 1, further input edges leave start_stamp_o, stop_stamp_o and elapsed_o unchanged until the next arm.
- R7: When the counter wraps between the two edges, stop_stamp_o is below start_stamp_o. elapsed_o still equals the true period.
- R8: An arm strobe drops done_o to 0 on the next clock. It discards any edge accepted in the same cycle and restarts capture from the first step, including when done_o was 1.
- R9: An arm strobe that arrives after the start edge but before the stop edge throws away the partial measurement. The next two edges form the new measurement.
- R10: Only rising edges are timestamped. The high time of the input has no effect on elapsed_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; it also drives the reference counter |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle strobe that starts a new measurement |
| sig_i | input | 1 | Asynchronous input signal to be measured |
| start_stamp_o | output | CNT_W | Counter value at the first accepted rising edge |
| stop_stamp_o | output | CNT_W | Counter value at the second accepted rising edge |
| elapsed_o | output | CNT_W | Stop minus start, modulo 2^CNT_W |
| done_o | output | 1 | High from completion until the next arm strobe |

## Verification
The assertions assume that arm_i is a clean synchronous strobe. They make no assumption about sig_i, because the filter and the step machine must tolerate any input pattern. The exact-period checks do rely on the input.

Every high phase and every low phase must last at least three sampling intervals, and the period must be a multiple of DIV_RATE. Then both edges see the same filter latency. The stimulus uses phases of 12 cycles or more and periods in steps of 4 cycles. It deliberately breaks the rule only with short glitches, which must be rejected.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int unsigned TS_W = 32;

    typedef enum logic [1:0] {
        STEP_WAIT_START = 2'd0,
        STEP_WAIT_STOP  = 2'd1,
        STEP_DONE       = 2'd2,
        STEP_SPARE      = 2'd3
    } step_e;
endpackage

// File: rtl/prd_refcnt.sv
module prd_refcnt #(
    parameter int unsigned    CNT_W    = 32,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.cnt <= CNT_INIT;
        else         st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/prd_filter.sv
module prd_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_RATE    = 4,
    parameter int unsigned FILT_LEN    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);
    localparam int unsigned PRE_W = (DIV_RATE > 1) ? $clog2(DIV_RATE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV_RATE - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [PRE_W-1:0]       pre;
        logic [FILT_LEN-1:0]    hist;
        logic                   level;
        logic                   rise;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     tick;
    logic     samp;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_comb st_d_sync_next = sig_i;
        end
    endgenerate

    logic [SYNC_STAGES-1:0] st_d_sync_next;
    generate
        if (SYNC_STAGES > 1) begin : g_syncn
            always_comb st_d_sync_next = {st_q.sync[SYNC_STAGES-2:0], sig_i};
        end
    endgenerate

    assign samp = st_q.sync[SYNC_STAGES-1];
    assign tick = (st_q.pre == PRE_LAST);

    always_comb begin
        st_d      = st_q;
        st_d.sync = st_d_sync_next;
        st_d.rise = 1'b0;
        st_d.pre  = tick ? '0 : st_q.pre + PRE_W'(1);
        if (tick) begin
            st_d.hist = {st_q.hist[FILT_LEN-2:0], samp};
            if (&st_d.hist) begin
                st_d.level = 1'b1;
                st_d.rise  = !st_q.level;
            end else if (~|st_d.hist) begin
                st_d.level = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.rise;
endmodule

// File: rtl/prd_stepper.sv
module prd_stepper
    import prd_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] stop_o,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             done_o
);
    typedef struct packed {
        step_e            step;
        logic             cap_en;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] elapsed;
        logic             done;
    } step_st_t;

    step_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d.step   = STEP_WAIT_START;
            st_d.cap_en = 1'b1;
            st_d.done   = 1'b0;
        end else if (rise_i && st_q.cap_en) begin
            unique case (st_q.step)
                STEP_WAIT_START: begin
                    st_d.start = cnt_i;
                    st_d.step  = STEP_WAIT_STOP;
                end
                STEP_WAIT_STOP: begin
                    st_d.stop    = cnt_i;
                    st_d.elapsed = cnt_i - st_q.start;
                    st_d.cap_en  = 1'b0;
                    st_d.done    = 1'b1;
                    st_d.step    = STEP_DONE;
                end
                default: begin
                    st_d.cap_en = 1'b0;
                    st_d.step   = STEP_WAIT_START;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign start_o   = st_q.start;
    assign stop_o    = st_q.stop;
    assign elapsed_o = st_q.elapsed;
    assign done_o    = st_q.done;
endmodule

// File: rtl/period_capture_top.sv
module period_capture_top
    import prd_pkg::*;
#(
    parameter int unsigned      CNT_W       = TS_W,
    parameter logic [CNT_W-1:0] CNT_INIT    = '0,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter int unsigned      DIV_RATE    = 4,
    parameter int unsigned      FILT_LEN    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             sig_i,
    output logic [CNT_W-1:0] start_stamp_o,
    output logic [CNT_W-1:0] stop_stamp_o,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             done_o
);
    logic [CNT_W-1:0] ref_cnt;
    logic             rise;

    prd_refcnt #(
        .CNT_W    (CNT_W),
        .CNT_INIT (CNT_INIT)
    ) u_refcnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (ref_cnt)
    );

    prd_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .DIV_RATE    (DIV_RATE),
        .FILT_LEN    (FILT_LEN)
    ) u_filter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    prd_stepper #(
        .CNT_W (CNT_W)
    ) u_stepper (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (arm_i),
        .rise_i    (rise),
        .cnt_i     (ref_cnt),
        .start_o   (start_stamp_o),
        .stop_o    (stop_stamp_o),
        .elapsed_o (elapsed_o),
        .done_o    (done_o)
    );
endmodule

// File: rtl/period_capture_chk.sv
module period_capture_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             arm_i,
    input logic [CNT_W-1:0] start_stamp_o,
    input logic [CNT_W-1:0] stop_stamp_o,
    input logic [CNT_W-1:0] elapsed_o,
    input logic             done_o
);
    // R8
    arm_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> !done_o);

    // R5
    elapsed_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (elapsed_o == stop_stamp_o - start_stamp_o));

    // R6
    hold_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !arm_i) |=> (done_o && $stable(start_stamp_o)
                                && $stable(stop_stamp_o) && $stable(elapsed_o)));

    // R6
    start_only_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(start_stamp_o) |-> !done_o);

    // R5
    done_rise_new_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> !$past(arm_i));
endmodule

bind period_capture_top period_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         (arm_i),
    .start_stamp_o (start_stamp_o),
    .stop_stamp_o  (stop_stamp_o),
    .elapsed_o     (elapsed_o),
    .done_o        (done_o)
);

// File: tb/period_capture_top_tb_top.sv
module period_capture_top_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  W = 32;
    localparam logic [W-1:0] WRAP_INIT = 32'hFFFF_FF60;
    localparam int  WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic sig = 1'b0;
    logic [W-1:0] st_a, sp_a, el_a, st_b, sp_b, el_b;
    logic dn_a, dn_b;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_capture_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sig_i(sig),
        .start_stamp_o(st_a), .stop_stamp_o(sp_a), .elapsed_o(el_a), .done_o(dn_a));

    period_capture_top #(.CNT_INIT(WRAP_INIT)) dut_wrap_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sig_i(sig),
        .start_stamp_o(st_b), .stop_stamp_o(sp_b), .elapsed_o(el_b), .done_o(dn_b));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_arm();
        arm = 1'b1;
        tick(1);
        arm = 1'b0;
    endtask

    task automatic edge_cycle(input int p, input int h);
        sig = 1'b1;
        tick(h);
        sig = 1'b0;
        tick(p - h);
    endtask

    // two edges, settle, verify period, then a third edge must be ignored
    task automatic measure(input int p, input int h);
        logic [W-1:0] s0, s1, e0;
        pulse_arm();
        check(dn_a == 1'b0, "R8 done cleared after arm", W'(dn_a), 0);
        tick(16);
        edge_cycle(p, h);
        edge_cycle(p, h);
        tick(24);
        check(dn_a == 1'b1, "R5 done after two edges", W'(dn_a), 1);
        check(el_a == W'(p), "R5 R2 R10 elapsed equals period", el_a, W'(p));
        check(sp_a - st_a == W'(p), "R5 stop minus start", sp_a - st_a, W'(p));
        s0 = st_a; s1 = sp_a; e0 = el_a;
        edge_cycle(p, h);
        tick(24);
        check(st_a == s0 && sp_a == s1 && el_a == e0, "R6 stamps held after done", sp_a, s1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        check(dn_a == 0 && st_a == 0 && sp_a == 0 && el_a == 0, "R1 reset outputs", st_a, 0);
        rst_n = 1'b1;
        tick(1);
        check(dn_b == 0 && st_b == 0 && sp_b == 0 && el_b == 0, "R1 outputs after reset", st_b, 0);

        // R4: edges without arm
        edge_cycle(32, 16);
        edge_cycle(32, 16);
        tick(40);
        check(dn_a == 0, "R4 no done without arm", W'(dn_a), 0);
        check(st_a == 0, "R4 no start stamp without arm", st_a, 0);

        // R7: wrap instance crosses all-ones during this measurement
        pulse_arm();
        tick(8);
        edge_cycle(64, 20);
        edge_cycle(64, 20);
        tick(24);
        check(dn_b == 1, "R7 done with wrap", W'(dn_b), 1);
        check(sp_b < st_b, "R7 stop below start after wrap", sp_b, st_b);
        check(el_b == 64, "R7 elapsed across wrap", el_b, 64);

        // R8: arm while done clears next cycle
        pulse_arm();
        check(dn_a == 0, "R8 arm in done state", W'(dn_a), 0);

        // R3: short glitches rejected
        tick(16);
        sig = 1'b1; tick(3); sig = 1'b0; tick(20);
        sig = 1'b1; tick(2); sig = 1'b0; tick(20);
        sig = 1'b1; tick(3); sig = 1'b0; tick(40);
        check(dn_a == 0, "R3 glitches not captured", W'(dn_a), 0);

        // R9: re-arm after start edge
        pulse_arm();
        tick(16);
        edge_cycle(40, 20);
        pulse_arm();
        tick(16);
        edge_cycle(28, 14);
        edge_cycle(28, 14);
        tick(24);
        check(dn_a == 1 && el_a == 28, "R9 re-arm mid measurement", el_a, 28);

        // sweep of periods and duty cycles
        for (int p = 24; p <= 64; p += 4) begin
            measure(p, 12);
            measure(p, p - 12);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule